// File: doc/BRIEF.md
# Branch condition evaluator

This block decides whether a condition holds against the processor's zero, sign and carry flags. A 3-bit condition code picks one of eight tests, and a separate invert bit can complement the outcome. One evaluation feeds two consumers. The conditional branch path reads the single `taken` bit. The set-on-condition instruction reads the same outcome as a full data word holding 1 or 0, which it writes into the selected accumulator. Flag generation and program-counter update happen outside this block.

The block accepts a request when `in_valid` is high. On the next clock it presents the registered outcome with `out_valid` high. A two-state output machine tracks whether a fresh result is on the outputs. State `ST_IDLE` means no new result this cycle. State `ST_VALID` means a result produced by the previous cycle's request is on the outputs. The transition `START` (any state to `ST_VALID`) is taken whenever `in_valid` is high. The transition `DRAIN` (any state to `ST_IDLE`) is taken whenever `in_valid` is low. Reset enters `ST_IDLE`. The result registers load only on an accepted request and otherwise keep their value.

Top module: `cond_eval_top`

## Requirements
- R1: Condition code 0 evaluates false when invert is 0.
- R2: Code 1 evaluates to the zero flag, and code 2 evaluates to the sign flag.
- R3: Code 3 is true when the sign flag or the zero flag is set.
- R4: Code 4 is true when the carry flag is clear.
- R5: Code 5 is true when the carry flag is clear or the zero flag is set.
- R6: Codes 6 and 7 evaluate true whatever the flags, when invert is 0.
- R7: When invert is 1, the outcome is the complement of the code's test. For example, code 0 with invert 1 is always true.
- R8: `scc_value` equals the outcome zero-extended to DATA_W bits (value 1 or 0), whenever `taken` is 1 or 0 respectively.
- R9: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high at the clock edge. `taken` and `scc_value` in that cycle reflect that request.
- R10: In a cycle with `in_valid` low, the request inputs have no effect: `taken` and `scc_value` keep their previous values on the next cycle.
- R11: After reset, `out_valid`, `taken` and `scc_value` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; inputs below are sampled when high |
| cond_code | input | 3 | Condition selector, codes 0 to 7 |
| invert | input | 1 | 1 complements the selected test |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_c | input | 1 | Carry flag |
| out_valid | output | 1 | High in the cycle after an accepted request |
| taken | output | 1 | Registered condition outcome (branch taken) |
| scc_value | output | DATA_W | Outcome as a data word, 1 or 0 |

## Verification
A wrong decode of one code shows as a bad `taken` bit on the very next cycle, but only when the flags happen to separate the wrong test from the right one. For that reason, every code is driven with all eight flag combinations, both with and without invert. A stuck or wrongly advanced output state appears as `out_valid` disagreeing with the previous cycle's strobe. A result register that loads when it should hold shows as `taken` or `scc_value` changing one cycle after an idle request. Both of these faults are visible within one clock.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CC_NEVER   = 3'd0,
        CC_ZERO    = 3'd1,
        CC_SIGN    = 3'd2,
        CC_SIGN_OR_ZERO = 3'd3,
        CC_NO_CARRY     = 3'd4,
        CC_NO_CARRY_OR_ZERO = 3'd5,
        CC_ALWAYS_A = 3'd6,
        CC_ALWAYS_B = 3'd7
    } cond_code_e;

    typedef struct packed {
        logic z;
        logic s;
        logic c;
    } flags_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } out_state_e;

endpackage

// File: rtl/cond_eval_logic.sv
module cond_eval_logic
    import cond_eval_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              invert,
    input  flags_t            flags,
    output logic              outcome
);

    logic test_raw;

    always_comb begin
        unique case (cond_code_e'(code))
            CC_NEVER:            test_raw = 1'b0;
            CC_ZERO:             test_raw = flags.z;
            CC_SIGN:             test_raw = flags.s;
            CC_SIGN_OR_ZERO:     test_raw = flags.s | flags.z;
            CC_NO_CARRY:         test_raw = ~flags.c;
            CC_NO_CARRY_OR_ZERO: test_raw = ~flags.c | flags.z;
            CC_ALWAYS_A:         test_raw = 1'b1;
            CC_ALWAYS_B:         test_raw = 1'b1;
            default:             test_raw = 1'b0;
        endcase
        outcome = test_raw ^ invert;
    end

endmodule

// File: rtl/cond_eval_outreg.sv
module cond_eval_outreg
    import cond_eval_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              outcome,
    output logic              out_valid,
    output logic              taken,
    output logic [DATA_W-1:0] scc_value
);

    localparam int PAD_W = DATA_W - 1;

    out_state_e state_q;
    out_state_e state_d;
    logic       taken_q;

    // next-state selection: START on load, DRAIN otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = load ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = load ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            taken_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                taken_q <= outcome;
            end
        end
    end

    always_comb begin
        out_valid = (state_q == ST_VALID);
        taken     = taken_q;
        scc_value = {{PAD_W{1'b0}}, taken_q};
    end

    // R9: a request yields out_valid on the next cycle
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> out_valid);

    // R9: no out_valid without a request one cycle earlier
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !out_valid);

    // R10: the result holds across an idle cycle
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(taken_q));

    // R9: the registered result equals the outcome presented with the request
    a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (taken_q == $past(outcome)));

endmodule

// File: rtl/cond_eval_top.sv
module cond_eval_top
    import cond_eval_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        cond_code,
    input  logic              invert,
    input  logic              flag_z,
    input  logic              flag_s,
    input  logic              flag_c,
    output logic              out_valid,
    output logic              taken,
    output logic [DATA_W-1:0] scc_value
);

    flags_t flags;
    logic   outcome;

    assign flags = '{z: flag_z, s: flag_s, c: flag_c};

    cond_eval_logic u_logic (
        .code    (cond_code),
        .invert  (invert),
        .flags   (flags),
        .outcome (outcome)
    );

    cond_eval_outreg #(.DATA_W(DATA_W)) u_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (in_valid),
        .outcome   (outcome),
        .out_valid (out_valid),
        .taken     (taken),
        .scc_value (scc_value)
    );

    // R1: code 0 without invert never yields taken
    a_r1_never: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_code == 3'd0 && !invert) |=> !taken);

    // R6: codes 6 and 7 without invert always yield taken
    a_r6_always: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_code[2:1] == 2'b11 && !invert) |=> taken);

    // R7: code 0 with invert always yields taken
    a_r7_inverted_never: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_code == 3'd0 && invert) |=> taken);

    // R8: the data word is the taken bit zero-extended
    a_r8_word_form: assert property (@(posedge clk) disable iff (!rst_n)
        scc_value == {{(DATA_W-1){1'b0}}, taken});

endmodule

// File: tb/cond_eval_top_bench.sv
module cond_eval_top_bench;

    localparam int DATA_W = 32;
    localparam int WATCHDOG_CYCLES = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [2:0]        cond_code = 3'd0;
    logic              invert = 1'b0;
    logic              flag_z = 1'b0;
    logic              flag_s = 1'b0;
    logic              flag_c = 1'b0;
    logic              out_valid;
    logic              taken;
    logic [DATA_W-1:0] scc_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic exp_taken = 1'b0;

    always #4 clk = ~clk;

    cond_eval_top #(.DATA_W(DATA_W)) u_cond_eval_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .cond_code (cond_code),
        .invert    (invert),
        .flag_z    (flag_z),
        .flag_s    (flag_s),
        .flag_c    (flag_c),
        .out_valid (out_valid),
        .taken     (taken),
        .scc_value (scc_value)
    );

    function automatic logic model(input logic [2:0] c, input logic inv,
                                   input logic z, input logic s, input logic cy);
        logic r;
        case (c)
            3'd0: r = 1'b0;
            3'd1: r = z;
            3'd2: r = s;
            3'd3: r = s | z;
            3'd4: r = !cy;
            3'd5: r = !cy | z;
            default: r = 1'b1;
        endcase
        return r ^ inv;
    endfunction

    function automatic string req_of(input logic [2:0] c, input logic inv);
        if (inv) return "R7";
        case (c)
            3'd0: return "R1";
            3'd1, 3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_word(input string req, input logic [DATA_W-1:0] act,
                              input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, result registered at next posedge, check at following negedge
    task automatic step(input logic v, input logic [2:0] c, input logic inv,
                        input logic z, input logic s, input logic cy);
        in_valid  = v;
        cond_code = c;
        invert    = inv;
        flag_z    = z;
        flag_s    = s;
        flag_c    = cy;
        @(negedge clk);
        if (v) begin
            exp_taken = model(c, inv, z, s, cy);
            check_bit(req_of(c, inv), taken, exp_taken);
            check_bit("R9", out_valid, 1'b1);
        end else begin
            check_bit("R9", out_valid, 1'b0);
            check_bit("R10", taken, exp_taken);
        end
        check_word("R8", scc_value, {{(DATA_W-1){1'b0}}, exp_taken});
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R11: reset state
        check_bit("R11", out_valid, 1'b0);
        check_bit("R11", taken, 1'b0);
        check_word("R11", scc_value, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // exhaustive directed sweep over code, invert and flags
        for (int i = 0; i < 128; i++) begin
            step(1'b1, i[2:0], i[3], i[4], i[5], i[6]);
        end

        // R10: idle cycles with provoking inputs after a true and a false result
        step(1'b1, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        step(1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        step(1'b0, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0);

        // constrained random mix of requests and idle cycles
        for (int n = 0; n < 600; n++) begin
            logic [7:0] r;
            r = 8'($urandom);
            step(($urandom % 4) != 0, r[2:0], r[3], r[4], r[5], r[6]);
        end

        // R11: reset mid-run clears the outputs
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        exp_taken = 1'b0;
        check_bit("R11", out_valid, 1'b0);
        check_bit("R11", taken, 1'b0);
        check_word("R11", scc_value, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule